// File: doc/BRIEF.md
# I2C EEPROM Write-Side Slave Engine

This block is the bus-facing front end of a 2048 x 8 serial EEPROM. It samples the two-wire bus lines on the system clock and finds START and STOP conditions. It then shifts in the control byte, checks the fixed device code, and keeps the three block-select bits that form the top of the byte address. It acknowledges or declines each byte by pulling SDA low during the ninth clock.

In a write transaction the engine takes the word address into an internal pointer and passes each accepted data byte to a page buffer, together with its 11-bit address. The pointer steps within a 16-byte page and wraps inside it. At STOP the engine raises a one-cycle commit strobe if any data was accepted, and the page buffer starts its internal write cycle on that strobe.

The acknowledge decision depends on memory state. While the busy input is high, every control byte is declined, so a master can poll for the end of a write cycle. While write protection is on, the control byte and the word address are still acknowledged, but the first data byte is refused and no commit follows.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: While and after reset, with the bus idle, sda_oe_o, wr_valid_o and wr_commit_o are all 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits are sampled on SCL rising edges, most significant bit first.
- R3: A control byte is acknowledged only when its upper nibble is 1010 and busy_i is low. Otherwise it gets no ACK, and the rest of that transaction is ignored until the next START.
- R4: sda_oe_o is high only during the ninth clock. It is set at the SCL falling edge that ends the eighth bit and cleared at the SCL falling edge that ends the ninth clock. It is never high while data bits are being shifted in.
- R5: In a write (control bit 0 = 0), the next byte is the word address. It is acknowledged, and the pointer is loaded as {control[3:1], word}.
- R6: Each acknowledged data byte gives exactly one wr_valid_o pulse, carrying the pointer on wr_addr_o and the byte on wr_data_o. The pointer then increments its low 4 bits, wrapping within the 16-byte page, and keeps its upper 7 bits.
- R7: If wp_i is high when a data byte completes, that byte is not acknowledged. It gives no wr_valid_o pulse, and the transaction gives no wr_commit_o.
- R8: A STOP after at least one accepted data byte gives exactly one wr_commit_o pulse. A STOP with no accepted data gives none.
- R9: A START in the middle of a byte aborts the transfer and discards any accepted data, so the following STOP gives no commit. A new control byte is then received from its first bit.
- R10: A read control byte (bit 0 = 1) is acknowledged when it matches and busy_i is low. After that the engine drives nothing until the next START or STOP.
- R11: A write control byte sent while busy_i is high gets no ACK. The same byte sent after busy_i falls gets an ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_i | input | 1 | Write protection active |
| sda_oe_o | output | 1 | Pull SDA low (ACK) when 1 |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr_o | output | 11 | Byte address of the accepted data |
| wr_data_o | output | 8 | Accepted data byte |
| wr_commit_o | output | 1 | One-cycle strobe at STOP to start the write cycle |

## Verification
The bench uses the default parameters: an 11-bit address, a 4-bit page offset and a two-stage synchronizer. With the 4-bit offset, a page write that starts at word 0x1E wraps from 0x01F to 0x010 within four bytes. The three block-select bits can all be set to non-zero values and appear in the address. Each SCL phase lasts eight system clocks, which is longer than the synchronizer and edge-detect latency, so the acknowledge is settled before every SCL rising edge the bench samples on.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;  // idle bus is high
      else         ff <= {ff[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/ee_bus_cond.sv
module ee_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/ee_byte_rx.sv
module ee_byte_rx #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_i,
  output logic            byte_done_o,
  output logic            ack_end_o,
  output logic [BITS-1:0] byte_o
);
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [BITS-1:0]  sh_q;
  logic             in_ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      in_ack_q <= 1'b0;
    end else if (start_i || stop_i) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
    end else if (scl_rise_i && !in_ack_q && cnt_q != FULL) begin
      sh_q  <= {sh_q[BITS-2:0], sda_i};
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (scl_fall_i && !in_ack_q && cnt_q == FULL) begin
      in_ack_q <= 1'b1;
    end else if (scl_fall_i && in_ack_q) begin
      in_ack_q <= 1'b0;
      cnt_q    <= '0;
    end
  end

  assign byte_done_o = scl_fall_i && !in_ack_q && (cnt_q == FULL) && !start_i && !stop_i;
  assign ack_end_o   = scl_fall_i && in_ack_q;
  assign byte_o      = sh_q;
endmodule

// File: rtl/ee_wr_fsm.sv
module ee_wr_fsm
  import ee_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic              ack_end_i,
  input  logic [7:0]        byte_i,
  input  logic              busy_i,
  input  logic              wp_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  localparam int BLK_W = ADDR_W - 8;

  ee_state_e         state_q;
  logic [BLK_W-1:0]  blk_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              pending_q;
  logic              ctrl_hit;

  assign ctrl_hit = (byte_i[7:4] == DEV_CODE) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      blk_q       <= '0;
      ptr_q       <= '0;
      pending_q   <= 1'b0;
      sda_oe_o    <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_CTRL;
        pending_q <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        wr_commit_o <= pending_q;
        pending_q   <= 1'b0;
        state_q     <= ST_IDLE;
        sda_oe_o    <= 1'b0;
      end else if (byte_done_i) begin
        unique case (state_q)
          ST_CTRL: begin
            if (ctrl_hit) begin
              sda_oe_o <= 1'b1;
              blk_q    <= byte_i[BLK_W:1];
              state_q  <= byte_i[0] ? ST_SKIP : ST_WADDR;
            end else begin
              state_q <= ST_SKIP;
            end
          end
          ST_WADDR: begin
            sda_oe_o <= 1'b1;
            ptr_q    <= {blk_q, byte_i};
            state_q  <= ST_WDATA;
          end
          ST_WDATA: begin
            if (!wp_i) begin
              sda_oe_o   <= 1'b1;
              wr_valid_o <= 1'b1;
              wr_addr_o  <= ptr_q;
              wr_data_o  <= byte_i;
              pending_q  <= 1'b1;
              ptr_q      <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
            end else begin
              pending_q <= 1'b0;
              state_q   <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end else if (ack_end_i) begin
        sda_oe_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic              wp_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  logic       scl_s, sda_s;
  logic       start, stop, scl_rise, scl_fall;
  logic       byte_done, ack_end;
  logic [7:0] rx_byte;

  ee_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  ee_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  ee_byte_rx #(.BITS(8)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .byte_done_o(byte_done),
    .ack_end_o  (ack_end),
    .byte_o     (rx_byte)
  );

  ee_wr_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .byte_done_i(byte_done),
    .ack_end_i  (ack_end),
    .byte_i     (rx_byte),
    .busy_i     (busy_i),
    .wp_i       (wp_i),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_commit_o(wr_commit_o)
  );
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic wr_valid_o,
  input logic wr_commit_o
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);  // R6
  AST_VALID_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> sda_oe_o);  // R6
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);  // R8
  AST_COMMIT_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> !sda_oe_o);  // R8
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);  // R4
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) && !$past(wr_commit_o) |-> !scl_s || $past(scl_s));  // R4
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (.*);

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int NVEC  = 10;
  // {control byte, busy, expected ack}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'hA0, 1'b0, 1'b1}, {8'hA2, 1'b0, 1'b1}, {8'hAE, 1'b0, 1'b1},
    {8'hA1, 1'b0, 1'b1}, {8'hB0, 1'b0, 1'b0}, {8'h20, 1'b0, 1'b0},
    {8'hA8, 1'b1, 1'b0}, {8'hA1, 1'b1, 1'b0}, {8'hE0, 1'b0, 1'b0},
    {8'hAF, 1'b0, 1'b1}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl = 1'b1, sda = 1'b1, busy = 1'b0, wp = 1'b0;
  logic        sda_oe, wr_valid, wr_commit;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  int total = 0, bad = 0, oe_err = 0;
  int nval = 0, ncommit = 0;
  logic [10:0] vaddr [64];
  logic [7:0]  vdata [64];

  always #(CLK_P/2) clk = ~clk;

  eeprom_i2c_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .busy_i(busy), .wp_i(wp), .sda_oe_o(sda_oe), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  always @(negedge clk) begin
    if (wr_valid && nval < 64) begin
      vaddr[nval] = wr_addr;
      vdata[nval] = wr_data;
      nval++;
    end
    if (wr_commit) ncommit++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda = 1'b1; wait_h();
    scl = 1'b1; wait_h();
    sda = 1'b0; wait_h();
    scl = 1'b0; wait_h();
  endtask

  task automatic i2c_stop();
    sda = 1'b0; wait_h();
    scl = 1'b1; wait_h();
    sda = 1'b1; wait_h();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda = b[i]; wait_h();
      scl = 1'b1; wait_h();
      if (sda_oe) oe_err++;
      scl = 1'b0; wait_h();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda = 1'b1; wait_h();
    scl = 1'b1; wait_h();
    ack = sda_oe;
    scl = 1'b0; wait_h();
    if (sda_oe) oe_err++;  // released after ninth clock
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    int v0, c0;
    repeat (5) @(negedge clk);
    check(sda_oe == 0 && wr_valid == 0 && wr_commit == 0, "R1 in reset",
          {sda_oe, wr_valid, wr_commit}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_oe == 0 && wr_valid == 0 && wr_commit == 0, "R1 after reset",
          {sda_oe, wr_valid, wr_commit}, 0);

    // control byte table: R3 match, R10 read, R11 busy
    for (int k = 0; k < NVEC; k++) begin
      busy = VEC[k][1];
      i2c_start();
      send_byte(VEC[k][9:2], ack);
      check(ack == VEC[k][0], "R3 control ack", ack, VEC[k][0]);
      i2c_stop();
    end
    busy = 1'b0;
    check(ncommit == 0 && nval == 0, "R8 no data no commit", ncommit + nval, 0);

    // byte write, block 3: R5 R6 R2 R8
    i2c_start();
    send_byte(8'hA6, ack); check(ack, "R3 write ctrl", ack, 1);
    send_byte(8'h5C, ack); check(ack, "R5 word addr ack", ack, 1);
    send_byte(8'h3D, ack); check(ack, "R6 data ack", ack, 1);
    i2c_stop();
    repeat (4) @(negedge clk);
    check(nval == 1 && vaddr[0] == 11'h35C, "R5 address", vaddr[0], 11'h35C);
    check(vdata[0] == 8'h3D, "R2 msb first data", vdata[0], 8'h3D);
    check(ncommit == 1, "R8 commit", ncommit, 1);

    // page write wrap: R6
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'h1E, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    send_byte(8'h44, ack);
    i2c_stop();
    repeat (4) @(negedge clk);
    check(nval == 5, "R6 byte count", nval, 5);
    check(vaddr[1] == 11'h01E && vaddr[2] == 11'h01F, "R6 step", vaddr[2], 11'h01F);
    check(vaddr[3] == 11'h010 && vdata[3] == 8'h33, "R6 wrap", vaddr[3], 11'h010);
    check(vaddr[4] == 11'h011 && vdata[4] == 8'h44, "R6 after wrap", vaddr[4], 11'h011);
    check(ncommit == 2, "R8 single commit per stop", ncommit, 2);

    // write protect: R7
    wp = 1'b1;
    i2c_start();
    send_byte(8'hA4, ack); check(ack, "R7 ctrl acked", ack, 1);
    send_byte(8'h40, ack); check(ack, "R7 addr acked", ack, 1);
    send_byte(8'h99, ack); check(!ack, "R7 data refused", ack, 0);
    i2c_stop();
    repeat (4) @(negedge clk);
    wp = 1'b0;
    check(nval == 5 && ncommit == 2, "R7 nothing written", nval * 16 + ncommit, 5 * 16 + 2);

    // polling: R11
    busy = 1'b1;
    i2c_start(); send_byte(8'hA0, ack); i2c_stop();
    check(!ack, "R11 busy nack", ack, 0);
    busy = 1'b0;
    i2c_start(); send_byte(8'hA0, ack); i2c_stop();
    check(ack, "R11 ready ack", ack, 1);

    // abort by START mid-byte: R9
    v0 = nval; c0 = ncommit;
    i2c_start();
    send_byte(8'hA0, ack);
    send_byte(8'h10, ack);
    send_byte(8'h55, ack);
    send_bits(8'hC0, 3);
    i2c_start();
    send_byte(8'hA2, ack); check(ack, "R9 new ctrl after abort", ack, 1);
    i2c_stop();
    repeat (4) @(negedge clk);
    check(nval == v0 + 1, "R9 data before abort", nval, v0 + 1);
    check(ncommit == c0, "R9 no commit after abort", ncommit, c0);

    // read silence: R10
    i2c_start();
    send_byte(8'hA1, ack); check(ack, "R10 read ctrl ack", ack, 1);
    send_byte(8'hFF, ack); check(!ack, "R10 silent after read", ack, 0);
    i2c_stop();

    check(oe_err == 0, "R4 oe outside ninth clock", oe_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule